// File: doc/BRIEF.md
# Mirrored Multi-Controller Port Arbiter

This block sits between N user ports and N storage controllers that all speak the same packet interface, so that every controller holds an identical copy of the data. In read mode the ports are independent. Port i talks only to controller i, so N reads proceed side by side and the total read rate scales with the number of controllers. The capacity seen through any port is that of a single controller.

A write from any port takes priority over reads. As soon as a write command is visible on some port, no further read is accepted anywhere, and the block waits until every read already handed to a controller has delivered its closing response. It then enters write mode. In write mode one writer at a time is granted, and each of its beats is offered to all controllers in the same cycle. All other ports are held off. The write rate is therefore bounded by the slowest controller.

Once every controller has answered the write, the granted port receives one merged reply. The next waiting writer, if any, is served in round-robin order. When no writer remains, the block falls back to read mode.

Top module: `mirror_arbiter`

## Requirements
- R1: After a synchronous reset, no controller request valid and no port response valid is asserted, and the block is in read mode.
- R2: In read mode, a read command on port i (write=0, single beat with eop=1) is forwarded only to controller i, and the response beats of controller i are returned unchanged to port i. Reads on different ports are accepted concurrently.
- R3: While any port presents a write command (valid=1, write=1), no read command is accepted on any port. No write beat reaches a controller before every accepted read has returned its closing beat (eop=1, last=1).
- R4: Each write beat of the granted port is presented to all controllers in the same cycle. It is presented, and acknowledged to the port, only in a cycle where every controller is ready.
- R5: While a write is being served, the ready signal of every port other than the granted one stays low.
- R6: After the final write beat, the granted port receives exactly one reply beat with eop=1, last=1 and write=1, and only after every controller has returned its closing beat. Its failed flag is the OR of the controllers' failed flags.
- R7: When several ports present writes, they are granted one at a time in round-robin order, starting after the most recently served writer. After reset, port 0 is first.
- R8: When a write reply is taken and no write is waiting, the block returns to read mode and accepts reads again.
- R9: Data written through any port is read back identically through every port, because every controller received the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_valid | input | N_PORTS | Port command/data beat valid |
| us_ready | output | N_PORTS | Port command/data beat accepted |
| us_eop | input | N_PORTS | Last beat of the port's command packet |
| us_write | input | N_PORTS | 1 = write packet, 0 = read packet |
| us_addr | input | N_PORTS x AW | Start address of the packet |
| us_data | input | N_PORTS x DW | Write data beat |
| ur_valid | output | N_PORTS | Port response beat valid |
| ur_ready | input | N_PORTS | Port accepts the response beat |
| ur_eop | output | N_PORTS | Last beat of the response packet |
| ur_write | output | N_PORTS | Response belongs to a write |
| ur_last | output | N_PORTS | Closing packet of the transaction |
| ur_failed | output | N_PORTS | Error reported for the transaction |
| ur_data | output | N_PORTS x DW | Read data beat |
| cs_valid | output | N_PORTS | Controller request beat valid |
| cs_ready | input | N_PORTS | Controller accepts the request beat |
| cs_eop | output | N_PORTS | Last beat of the request packet |
| cs_write | output | N_PORTS | Request is a write |
| cs_addr | output | N_PORTS x AW | Request address |
| cs_data | output | N_PORTS x DW | Request write data |
| cr_valid | input | N_PORTS | Controller response beat valid |
| cr_ready | output | N_PORTS | Response beat accepted |
| cr_eop | input | N_PORTS | Last beat of the response packet |
| cr_write | input | N_PORTS | Response belongs to a write |
| cr_last | input | N_PORTS | Closing packet of the transaction |
| cr_failed | input | N_PORTS | Controller error flag |
| cr_data | input | N_PORTS x DW | Controller read data |

## Verification
The assertions assume that each controller drives ready without looking at valid. They assume a controller never returns a closing beat for a read it did not accept and answers each accepted command with exactly one closing beat. They also assume a port keeps valid and its command fields steady until the beat is taken. The bench's controller models raise ready only from their own idle phase and a free-running stall pattern, and they answer every command with one closing beat after a fixed per-controller delay. Its port drivers hold each beat until they see ready in the stable low half of the clock.

// File: rtl/mir_pkg.sv
package mir_pkg;
  typedef enum logic [2:0] {
    ST_READ   = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_WDATA  = 3'd2,
    ST_WRESP  = 3'd3,
    ST_WREPLY = 3'd4
  } mir_state_e;
endpackage

// File: rtl/mir_rr_pick.sv
module mir_rr_pick #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] pick
);
  // Scan from the farthest candidate to the nearest so the nearest wins.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = N; i >= 1; i--) begin
      int k;
      k = (int'(last) + i) % N;
      if (req[k]) begin
        found = 1'b1;
        pick  = IW'(k);
      end
    end
  end
endmodule

// File: rtl/mir_read_track.sv
module mir_read_track #(
  parameter int OUTW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic busy,
  output logic full
);
  logic [OUTW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && !dec) cnt <= cnt + 1'b1;
    else if (dec && !inc) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign full = (cnt == {OUTW{1'b1}});

  // R3: a closing read beat always has an accepted read behind it
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt != '0))
    else $error("read closed with nothing in flight");

  // R3: reads are refused before the flight counter wraps
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    inc |-> (cnt != {OUTW{1'b1}}))
    else $error("read flight counter overflow");
endmodule

// File: rtl/mir_write_collect.sv
module mir_write_collect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic [N-1:0] done_beat,
  input  logic [N-1:0] fail_beat,
  output logic [N-1:0] got,
  output logic         all_got,
  output logic         any_fail
);
  logic [N-1:0] fl;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      got <= '0;
      fl  <= '0;
    end else begin
      got <= got | done_beat;
      fl  <= fl | (done_beat & fail_beat);
    end
  end

  assign all_got  = &got;
  assign any_fail = |fl;

  // R6: each controller closes a write exactly once
  a_r6_close_once: assert property (@(posedge clk) disable iff (rst)
    (done_beat & got) == '0)
    else $error("controller closed a write twice");
endmodule

// File: rtl/mirror_arbiter.sv
module mirror_arbiter
  import mir_pkg::*;
#(
  parameter int N_PORTS = 2,
  parameter int DW      = 32,
  parameter int AW      = 48,
  parameter int OUTW    = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_PORTS-1:0]          us_valid,
  output logic [N_PORTS-1:0]          us_ready,
  input  logic [N_PORTS-1:0]          us_eop,
  input  logic [N_PORTS-1:0]          us_write,
  input  logic [N_PORTS-1:0][AW-1:0]  us_addr,
  input  logic [N_PORTS-1:0][DW-1:0]  us_data,
  output logic [N_PORTS-1:0]          ur_valid,
  input  logic [N_PORTS-1:0]          ur_ready,
  output logic [N_PORTS-1:0]          ur_eop,
  output logic [N_PORTS-1:0]          ur_write,
  output logic [N_PORTS-1:0]          ur_last,
  output logic [N_PORTS-1:0]          ur_failed,
  output logic [N_PORTS-1:0][DW-1:0]  ur_data,
  output logic [N_PORTS-1:0]          cs_valid,
  input  logic [N_PORTS-1:0]          cs_ready,
  output logic [N_PORTS-1:0]          cs_eop,
  output logic [N_PORTS-1:0]          cs_write,
  output logic [N_PORTS-1:0][AW-1:0]  cs_addr,
  output logic [N_PORTS-1:0][DW-1:0]  cs_data,
  input  logic [N_PORTS-1:0]          cr_valid,
  output logic [N_PORTS-1:0]          cr_ready,
  input  logic [N_PORTS-1:0]          cr_eop,
  input  logic [N_PORTS-1:0]          cr_write,
  input  logic [N_PORTS-1:0]          cr_last,
  input  logic [N_PORTS-1:0]          cr_failed,
  input  logic [N_PORTS-1:0][DW-1:0]  cr_data
);
  localparam int N  = N_PORTS;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  mir_state_e   state;
  logic [IW-1:0] grant, last_srv, rr_last, rr_pick;
  logic         rr_found;
  logic [N-1:0] wreq, busy, full, rd_inc, rd_dec, rd_open, wdone, got;
  logic         any_wreq, all_idle, all_rdy, all_got, any_fail, rd_phase;

  assign wreq     = us_valid & us_write;
  assign any_wreq = |wreq;
  assign all_idle = (busy == '0);
  assign all_rdy  = &cs_ready;
  assign rd_phase = (state == ST_READ) || (state == ST_DRAIN);
  assign rr_last  = (state == ST_WREPLY) ? grant : last_srv;

  mir_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req   (wreq),
    .last  (rr_last),
    .found (rr_found),
    .pick  (rr_pick)
  );

  for (genvar g = 0; g < N; g++) begin : g_ctrl
    assign rd_open[g] = (state == ST_READ) && !any_wreq && !full[g] && !us_write[g];
    assign rd_inc[g]  = cs_valid[g] && cs_ready[g] && !cs_write[g];
    assign rd_dec[g]  = rd_phase && cr_valid[g] && cr_ready[g] && cr_last[g] && cr_eop[g];
    assign wdone[g]   = (state == ST_WRESP) && cr_valid[g] && cr_ready[g]
                        && cr_last[g] && cr_eop[g];

    mir_read_track #(.OUTW(OUTW)) u_track (
      .clk  (clk),
      .rst  (rst),
      .inc  (rd_inc[g]),
      .dec  (rd_dec[g]),
      .busy (busy[g]),
      .full (full[g])
    );
  end

  mir_write_collect #(.N(N)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .clear     (state == ST_WDATA),
    .done_beat (wdone),
    .fail_beat (cr_failed),
    .got       (got),
    .all_got   (all_got),
    .any_fail  (any_fail)
  );

  // Mode sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_READ;
      grant    <= '0;
      last_srv <= IW'(N - 1);
    end else begin
      unique case (state)
        ST_READ:  if (any_wreq) state <= ST_DRAIN;
        ST_DRAIN: begin
          if (all_idle) begin
            if (rr_found) begin
              grant <= rr_pick;
              state <= ST_WDATA;
            end else begin
              state <= ST_READ;
            end
          end
        end
        ST_WDATA: if (us_valid[grant] && all_rdy && us_eop[grant]) state <= ST_WRESP;
        ST_WRESP: if (all_got) state <= ST_WREPLY;
        ST_WREPLY: begin
          if (ur_ready[grant]) begin
            last_srv <= grant;
            if (rr_found) begin
              grant <= rr_pick;
              state <= ST_WDATA;
            end else begin
              state <= ST_READ;
            end
          end
        end
        default: state <= ST_READ;
      endcase
    end
  end

  // Datapath steering
  always_comb begin
    cs_valid  = '0;
    cs_eop    = '0;
    cs_write  = '0;
    cs_addr   = '0;
    cs_data   = '0;
    us_ready  = '0;
    ur_valid  = '0;
    ur_eop    = '0;
    ur_write  = '0;
    ur_last   = '0;
    ur_failed = '0;
    ur_data   = '0;
    cr_ready  = '0;
    unique case (state)
      ST_READ, ST_DRAIN: begin
        for (int i = 0; i < N; i++) begin
          cs_eop[i]    = us_eop[i];
          cs_write[i]  = us_write[i];
          cs_addr[i]   = us_addr[i];
          cs_data[i]   = us_data[i];
          cs_valid[i]  = us_valid[i] && rd_open[i];
          us_ready[i]  = cs_ready[i] && rd_open[i];
          ur_valid[i]  = cr_valid[i];
          ur_eop[i]    = cr_eop[i];
          ur_write[i]  = cr_write[i];
          ur_last[i]   = cr_last[i];
          ur_failed[i] = cr_failed[i];
          ur_data[i]   = cr_data[i];
          cr_ready[i]  = ur_ready[i];
        end
      end
      ST_WDATA: begin
        for (int j = 0; j < N; j++) begin
          cs_eop[j]   = us_eop[grant];
          cs_write[j] = us_write[grant];
          cs_addr[j]  = us_addr[grant];
          cs_data[j]  = us_data[grant];
          cs_valid[j] = us_valid[grant] && all_rdy;
        end
        us_ready[grant] = all_rdy;
      end
      ST_WRESP: cr_ready = ~got;
      ST_WREPLY: begin
        ur_valid[grant]  = 1'b1;
        ur_eop[grant]    = 1'b1;
        ur_last[grant]   = 1'b1;
        ur_write[grant]  = 1'b1;
        ur_failed[grant] = any_fail;
      end
      default: ;
    endcase
  end

  // R3: no read leaves for a controller outside read mode
  a_r3_no_read_issue: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READ) |-> ((cs_valid & ~cs_write) == '0))
    else $error("read issued while a write is pending");

  // R3: write data starts only with every read closed
  a_r3_drained: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA) |-> (busy == '0))
    else $error("write started with reads in flight");

  // R4: a write beat reaches every controller or none
  a_r4_broadcast: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WDATA) && (cs_valid != '0)) |-> ((&cs_valid) && (&cs_ready)))
    else $error("partial write broadcast");

  // R5: at most one port moves outside read mode
  a_r5_one_port: assert property (@(posedge clk) disable iff (rst)
    (state != ST_READ) |-> $onehot0(us_ready))
    else $error("more than one port acked during write");

  // R6: the merged reply waits for all controllers
  a_r6_reply_complete: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WREPLY) |-> all_got)
    else $error("write reply before all controllers closed");
endmodule

// File: tb/mirror_arbiter_tb.sv
`timescale 1ns/1ps

module mir_ctrl_model #(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int IDX   = 0,
  parameter int LAT   = 3,
  parameter int STALL = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v,
  input  logic          eop,
  input  logic          wr,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] d,
  output logic          rdy,
  output logic          rv,
  output logic          reop,
  output logic          rlast,
  output logic          rfail,
  output logic          rwr,
  output logic [DW-1:0] rdat,
  input  logic          rrdy,
  input  logic          finj
);
  localparam int SM = (STALL > 0) ? STALL : 1;
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int cyc, tmr, ph, wk;
  logic iswr;
  logic [AW-1:0] ra;

  assign rdy   = (ph == 0) && !((STALL > 0) && ((cyc % SM) == 0));
  assign rv    = (ph == 2) || (ph == 3);
  assign reop  = rv;
  assign rlast = (ph == 3);
  assign rwr   = iswr;
  assign rfail = (ph == 3) && iswr && finj;
  assign rdat  = (ph == 2) ? mem[ra] : '0;

  always @(posedge clk) begin
    if (rst) begin
      ph <= 0; cyc <= 0; wk <= 0; tmr <= 0; iswr <= 1'b0; ra <= '0;
      for (int k = 0; k < (1<<AW); k++) mem[k] <= DW'(IDX*64 + k);
    end else begin
      cyc <= cyc + 1;
      case (ph)
        0: if (v && rdy) begin
             if (wr) begin
               mem[a + AW'(wk)] <= d;
               if (eop) begin ph <= 1; tmr <= LAT; iswr <= 1'b1; wk <= 0; end
               else wk <= wk + 1;
             end else begin
               ra <= a; ph <= 1; tmr <= LAT; iswr <= 1'b0;
             end
           end
        1: if (tmr == 0) ph <= iswr ? 3 : 2; else tmr <= tmr - 1;
        2: if (rrdy) ph <= 3;
        3: if (rrdy) ph <= 0;
        default: ph <= 0;
      endcase
    end
  end
endmodule

module mirror_arbiter_tb;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]         us_valid, us_ready, us_eop, us_write;
  logic [N-1:0][AW-1:0] us_addr;
  logic [N-1:0][DW-1:0] us_data;
  logic [N-1:0]         ur_valid, ur_ready, ur_eop, ur_write, ur_last, ur_failed;
  logic [N-1:0][DW-1:0] ur_data;
  logic [N-1:0]         cs_valid, cs_ready, cs_eop, cs_write;
  logic [N-1:0][AW-1:0] cs_addr;
  logic [N-1:0][DW-1:0] cs_data;
  logic [N-1:0]         cr_valid, cr_ready, cr_eop, cr_write, cr_last, cr_failed;
  logic [N-1:0][DW-1:0] cr_data;
  logic [N-1:0]         finj;

  mirror_arbiter #(.N_PORTS(N), .DW(DW), .AW(AW), .OUTW(2)) u_dut (
    .clk(clk), .rst(rst),
    .us_valid(us_valid), .us_ready(us_ready), .us_eop(us_eop), .us_write(us_write),
    .us_addr(us_addr), .us_data(us_data),
    .ur_valid(ur_valid), .ur_ready(ur_ready), .ur_eop(ur_eop), .ur_write(ur_write),
    .ur_last(ur_last), .ur_failed(ur_failed), .ur_data(ur_data),
    .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_eop(cs_eop), .cs_write(cs_write),
    .cs_addr(cs_addr), .cs_data(cs_data),
    .cr_valid(cr_valid), .cr_ready(cr_ready), .cr_eop(cr_eop), .cr_write(cr_write),
    .cr_last(cr_last), .cr_failed(cr_failed), .cr_data(cr_data)
  );

  for (genvar g = 0; g < N; g++) begin : g_model
    mir_ctrl_model #(.DW(DW), .AW(AW), .IDX(g),
                     .LAT((g == 0) ? 20 : ((g == 1) ? 3 : 6)),
                     .STALL((g == 2) ? 3 : 0)) u_model (
      .clk(clk), .rst(rst), .v(cs_valid[g]), .eop(cs_eop[g]), .wr(cs_write[g]),
      .a(cs_addr[g]), .d(cs_data[g]), .rdy(cs_ready[g]),
      .rv(cr_valid[g]), .reop(cr_eop[g]), .rlast(cr_last[g]), .rfail(cr_failed[g]),
      .rwr(cr_write[g]), .rdat(cr_data[g]), .rrdy(cr_ready[g]), .finj(finj[g])
    );
  end

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int mark = 0, seen_mark = 0, wb_first = 0;
  int bc_viol = 0, st_viol = 0;
  bit finished = 0;
  logic [DW-1:0] exp_mem [0:(1<<AW)-1];
  int acc [N], done [N], rep [N];
  logic [DW-1:0] rd [N];
  logic wf [N];
  int lastsrv;

  // Cycle counter and protocol monitors
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (|(cs_valid & cs_ready & cs_write) && seen_mark != mark) begin
        wb_first  <= cyc;
        seen_mark <= mark;
      end
      if (|(cs_valid & cs_write) && !((&cs_valid) && (&cs_ready))) bc_viol <= bc_viol + 1;
      if (|(cs_valid & cs_write) && ($countones(us_ready) > 1)) st_viol <= st_viol + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int p, int a, int r);
    return DW'(p*37 + a*11 + r*5 + 3);
  endfunction

  task automatic send_beat(input int p, input bit w, input bit e,
                           input logic [AW-1:0] a, input logic [DW-1:0] d, output int at);
    bit ok;
    us_valid[p] = 1'b1; us_write[p] = w; us_eop[p] = e; us_addr[p] = a; us_data[p] = d;
    do begin
      #1; ok = us_ready[p];
      @(negedge clk);
    end while (!ok);
    at = cyc;
    us_valid[p] = 1'b0;
  endtask

  task automatic do_read(input int p, input logic [AW-1:0] a,
                         output logic [DW-1:0] d, output int at, output int dn);
    bit fin;
    send_beat(p, 1'b0, 1'b1, a, '0, at);
    fin = 0; d = '0; dn = 0;
    while (!fin) begin
      #1;
      if (ur_valid[p]) begin
        if (ur_last[p]) begin fin = 1; dn = cyc; end
        else d = ur_data[p];
      end
      @(negedge clk);
    end
  endtask

  task automatic do_write(input int p, input int a, input int len, input int r,
                          output logic fl, output int rp);
    int at;
    bit fin;
    for (int k = 0; k < len; k++)
      send_beat(p, 1'b1, (k == len-1), AW'(a), pat(p, a+k, r), at);
    fin = 0; fl = 1'b0; rp = 0;
    while (!fin) begin
      #1;
      if (ur_valid[p]) begin
        fin = 1; rp = cyc; fl = ur_failed[p];
        chk(ur_last[p] && ur_write[p] && ur_eop[p], "R6 reply shape",
            {ur_last[p], ur_write[p], ur_eop[p]}, 7);
      end
      @(negedge clk);
    end
    for (int k = 0; k < len; k++) exp_mem[AW'(a+k)] = pat(p, a+k, r);
  endtask

  function automatic int rank(int p);
    return (p - lastsrv - 1 + 2*N) % N;
  endfunction

  task automatic rr_check(input logic [N-1:0] who);
    for (int p = 0; p < N; p++)
      for (int q = p+1; q < N; q++)
        if (who[p] && who[q])
          chk((rank(p) < rank(q)) == (rep[p] < rep[q]), "R7 round-robin order",
              rep[p] - rep[q], (rank(p) < rank(q)) ? -1 : 1);
  endtask

  initial begin
    us_valid = '0; us_eop = '0; us_write = '0; us_addr = '0; us_data = '0;
    ur_ready = '1; finj = '0; lastsrv = N - 1;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(cs_valid == '0, "R1 controller valid after reset", cs_valid, 0);
    chk(ur_valid == '0, "R1 port response after reset", ur_valid, 0);
    @(negedge clk);

    // R2: parallel reads on untouched addresses reveal the wiring
    fork
      do_read(0, 8'd200, rd[0], acc[0], done[0]);
      do_read(1, 8'd200, rd[1], acc[1], done[1]);
      do_read(2, 8'd200, rd[2], acc[2], done[2]);
    join
    for (int i = 0; i < N; i++) begin
      chk(rd[i] == DW'(i*64 + 200), "R2 port reaches own controller", rd[i], DW'(i*64 + 200));
      for (int j = 0; j < N; j++)
        chk(acc[i] < done[j], "R2 reads overlap", acc[i], done[j]);
    end

    // R4/R6/R9: sweep writers and lengths, read back through every port
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < N; p++)
        for (int len = 1; len <= 3; len++) begin
          int a;
          logic fl;
          int rp;
          a = p*16 + len*4 + r;
          do_write(p, a, len, r, fl, rp);
          lastsrv = p;
          chk(fl == 1'b0, "R6 failed clear", fl, 0);
          for (int q = 0; q < N; q++)
            for (int k = 0; k < len; k++) begin
              logic [DW-1:0] dd;
              int at, dn;
              do_read(q, AW'(a+k), dd, at, dn);
              chk(dd == exp_mem[AW'(a+k)], "R9 mirrored readback", dd, exp_mem[AW'(a+k)]);
            end
        end

    // R3/R5: slow read in flight, then a write, then a read during the drain
    mark = mark + 1;
    fork
      do_read(0, 8'd5, rd[0], acc[0], done[0]);
      begin repeat (3) @(negedge clk); do_write(1, 100, 2, 7, wf[1], rep[1]); end
      begin repeat (5) @(negedge clk); do_read(2, 8'd210, rd[2], acc[2], done[2]); end
    join
    lastsrv = 1;
    chk(seen_mark == mark, "R3 write reached controllers", seen_mark, mark);
    chk(wb_first > done[0], "R3 write waits for read drain", wb_first, done[0] + 1);
    chk(acc[2] > rep[1], "R3 read held while write pending", acc[2], rep[1] + 1);
    chk(acc[2] > rep[1], "R5 other port stalled during write", acc[2], rep[1] + 1);
    chk(rd[2] == DW'(2*64 + 210), "R8 read after write mode", rd[2], DW'(2*64 + 210));
    chk(rd[0] == exp_mem[5], "R9 drained read data", rd[0], exp_mem[5]);

    // R6: failed flag is the OR over controllers
    finj = 3'b010;
    do_write(2, 110, 1, 3, wf[2], rep[2]);
    lastsrv = 2;
    chk(wf[2] == 1'b1, "R6 failed OR one controller", wf[2], 1);
    finj = 3'b101;
    do_write(0, 111, 2, 3, wf[0], rep[0]);
    lastsrv = 0;
    chk(wf[0] == 1'b1, "R6 failed OR two controllers", wf[0], 1);
    finj = '0;

    // R7: all three writers at once
    fork
      do_write(0, 120, 2, 4, wf[0], rep[0]);
      do_write(1, 123, 1, 4, wf[1], rep[1]);
      do_write(2, 125, 3, 4, wf[2], rep[2]);
    join
    rr_check(3'b111);
    lastsrv = (rep[0] > rep[1]) ? ((rep[0] > rep[2]) ? 0 : 2) : ((rep[1] > rep[2]) ? 1 : 2);
    // R7: after port 1 alone, port 2 must precede port 0
    do_write(1, 90, 1, 5, wf[1], rep[1]);
    lastsrv = 1;
    fork
      do_write(0, 92, 1, 5, wf[0], rep[0]);
      do_write(2, 94, 1, 5, wf[2], rep[2]);
    join
    rr_check(3'b101);
    chk(rep[2] < rep[0], "R7 rotation past port 1", rep[2], rep[0] - 1);

    // R8/R9: back in read mode, parallel readback of the contended writes
    fork
      do_read(0, 8'd120, rd[0], acc[0], done[0]);
      do_read(1, 8'd123, rd[1], acc[1], done[1]);
      do_read(2, 8'd127, rd[2], acc[2], done[2]);
    join
    chk(rd[0] == exp_mem[120], "R8 read mode restored p0", rd[0], exp_mem[120]);
    chk(rd[1] == exp_mem[123], "R8 read mode restored p1", rd[1], exp_mem[123]);
    chk(rd[2] == exp_mem[127], "R9 mirrored burst tail", rd[2], exp_mem[127]);

    @(negedge clk);
    chk(bc_viol == 0, "R4 broadcast to all controllers", bc_viol, 0);
    chk(st_viol == 0, "R5 single port during write", st_viol, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule